// File: doc/BRIEF.md
# System Controller with Interval Timers

This block is a 32-bit register-mapped peripheral for a small system-on-chip. It holds a general-purpose pin group, two identical up-counting interval timers, a configuration-port command word, a read-only capabilities word and a system identification word. Software reaches all of it over a simple single-cycle bus. The bus takes a word index, a write strobe and write data. Read data is combinational from the index.

Each timer counts up from its counter value while enabled. When the counter equals the compare value, the timer raises its interrupt line for one cycle. In one-shot mode the timer then clears its own enable bit and holds the counter at the compare value. In auto-restart mode it stays enabled and the counter wraps to zero. The pin group samples its inputs through a two-flop synchronizer and raises a one-cycle interrupt when an enabled input bit changes. Two more one-cycle strobes ask the surrounding system for a shutdown or a reset.

Top module: `soc_sysctl`

## Requirements
- R1: After reset, every word index reads zero, with these exceptions: index 13 (config command) reads 0x1, index 15 (system ID) reads the SYSID parameter (default 0x10014D31), index 14 (capabilities) reads the CAPS parameter (default 0), and index 0 (pin input) reads the strapping value STRAP (default 0x1). All outputs are low.
- R2: Index 1 (pin output) and index 2 (pin interrupt enable) store the low GPIO_W bits of a write. They read back zero-extended, and `gpio_out` follows index 1.
- R3: Timer t uses index 4+4t for control (bit 0 enable, bit 1 auto-restart), 5+4t for compare and 6+4t for counter. In one-shot mode, with the counter written to S and compare C (S<=C), enabling the timer raises `irq_timer[t]` exactly C-S+1 clock edges after the enabling write, for one cycle. The control word then reads 0 and the counter reads C.
- R4: With auto-restart set, a compare hit leaves the enable bit set and the counter returns to zero on the hit edge. The interrupt therefore repeats every C+1 cycles.
- R5: A counter write with a value greater than the current compare value stores the compare value.
- R6: A write to index 13 whose low 16 bits equal 0x000E produces a one-cycle `shutdown_req` in the cycle after the write. Any other value gives no pulse, and index 13 keeps reading 0x1.
- R7: Any write to index 15 produces a one-cycle `reset_req` in the cycle after the write. The ID value is unchanged.
- R8: Writes to index 0 (pin input) and index 14 (capabilities) have no effect.
- R9: Index 0 reflects `gpio_in` two clock edges after the pins change. When a changed bit has its enable bit set, `irq_gpio` is high for exactly one cycle, three edges after the change. Changes on disabled bits raise no interrupt.
- R10: Reserved indices 3, 7, 11 and 12 read zero, and writes to them are ignored.
- R11: An enabled timer's counter advances by one per clock and can be read while running. A disabled timer holds its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| gpio_in | input | GPIO_W | Asynchronous input pins |
| gpio_out | output | GPIO_W | Output pins |
| irq_gpio | output | 1 | One-cycle pin-change interrupt |
| irq_timer | output | 2 | One-cycle interrupt per timer |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact edge count from the enabling write to the one-shot pulse, and from one auto-restart pulse to the next. A design with an off-by-one compare, or one that wraps to one instead of zero, misses those counts. It writes a counter value above the compare value: a design without clipping would run until the counter wraps and never hit. It also checks that a one-shot hit clears the enable bit but an auto-restart hit does not. It toggles a masked and an unmasked input bit and checks the pulse position against the two-stage synchronizer, which catches a missing stage or a level-sensitive interrupt. It sends a non-matching command word to show that only the 0x000E pattern requests shutdown.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W    = 32;
    localparam int IDX_W     = 4;
    localparam int N_TMR     = 2;
    localparam int TMR_BASE  = 4;
    localparam int TMR_PITCH = 4;

    localparam logic [IDX_W-1:0] IDX_PIN_IN  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_PIN_OUT = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PIN_IEN = 4'd2;
    localparam logic [IDX_W-1:0] IDX_CFG_CMD = 4'd13;
    localparam logic [IDX_W-1:0] IDX_CAPS    = 4'd14;
    localparam logic [IDX_W-1:0] IDX_SYSID   = 4'd15;

    localparam logic [15:0]       CMD_SHUTDOWN = 16'h000E;
    localparam logic [DATA_W-1:0] CFG_READY    = 32'h0000_0001;

    typedef enum logic [1:0] {
        TF_CTRL = 2'd0,
        TF_CMP  = 2'd1,
        TF_CNT  = 2'd2
    } tmr_field_e;

    typedef struct packed {
        logic autorst;
        logic enable;
    } tmr_ctrl_t;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [IDX_W-1:0] tmr_idx(input int unsigned t, input tmr_field_e f);
        return IDX_W'(TMR_BASE + TMR_PITCH * t + int'(f));
    endfunction

    function automatic logic [DATA_W-1:0] clip_to(input logic [DATA_W-1:0] v,
                                                  input logic [DATA_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer
    import sysctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctrl,
    input  logic      wr_cmp,
    input  logic      wr_cnt,
    input  logic [W-1:0] wdata,
    output tmr_ctrl_t ctrl_q,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] cnt_q,
    output logic      hit_q
);

    logic hit;

    // A hit needs the timer enabled and the counter equal to the compare value.
    assign hit = ctrl_q.enable && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
            hit_q  <= 1'b0;
        end else begin
            hit_q <= hit;

            if (wr_cmp) begin
                cmp_q <= wdata;
            end

            // A bus write wins over the hardware self-clear.
            if (wr_ctrl) begin
                ctrl_q <= tmr_ctrl_t'(wdata[1:0]);
            end else if (hit && !ctrl_q.autorst) begin
                ctrl_q.enable <= 1'b0;
            end

            if (wr_cnt) begin
                cnt_q <= clip_to(wdata, cmp_q);
            end else if (hit) begin
                if (ctrl_q.autorst) begin
                    cnt_q <= '0;
                end
            end else if (ctrl_q.enable) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysctl_gpio.sv
module sysctl_gpio #(
    parameter int               W     = 8,
    parameter logic [W-1:0]     STRAP = W'(1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] irq_en,
    output logic [W-1:0] level,
    output logic         irq_q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] changed;

    assign level   = sync_q;
    assign changed = (sync_q ^ prev_q) & irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= STRAP;
            sync_q <= STRAP;
            prev_q <= STRAP;
            irq_q  <= 1'b0;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
            prev_q <= sync_q;
            irq_q  <= |changed;
        end
    end

endmodule

// File: rtl/soc_sysctl.sv
module soc_sysctl
    import sysctl_pkg::*;
#(
    parameter int                  GPIO_W = 8,
    parameter logic [GPIO_W-1:0]   STRAP  = GPIO_W'(1),
    parameter logic [DATA_W-1:0]   CAPS   = 32'h0000_0000,
    parameter logic [DATA_W-1:0]   SYSID  = 32'h1001_4D31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [IDX_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [GPIO_W-1:0]    gpio_in,
    output logic [GPIO_W-1:0]    gpio_out,
    output logic                 irq_gpio,
    output logic [N_TMR-1:0]     irq_timer,
    output logic                 shutdown_req,
    output logic                 reset_req
);

    bus_req_t          req;
    logic [GPIO_W-1:0] pin_out_q;
    logic [GPIO_W-1:0] pin_ien_q;
    logic [GPIO_W-1:0] pin_level;
    logic              shutdown_q;
    logic              reset_q;

    tmr_ctrl_t         tmr_ctrl [N_TMR];
    logic [DATA_W-1:0] tmr_cmp  [N_TMR];
    logic [DATA_W-1:0] tmr_cnt  [N_TMR];
    logic [N_TMR-1:0]  tmr_en_v;
    logic [N_TMR-1:0]  tmr_auto_v;

    logic [DATA_W-1:0] misc_rdata;
    logic [DATA_W-1:0] tmr_rdata;

    assign req = '{we: bus_we, idx: bus_addr, wdata: bus_wdata};

    // Pin group: synchronizer, change detector and interrupt.
    sysctl_gpio #(
        .W     (GPIO_W),
        .STRAP (STRAP)
    ) i_gpio (
        .clk    (clk),
        .rst    (rst),
        .pins   (gpio_in),
        .irq_en (pin_ien_q),
        .level  (pin_level),
        .irq_q  (irq_gpio)
    );

    // Interval timers, one instance per slot in the map.
    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        logic wr_ctrl;
        logic wr_cmp;
        logic wr_cnt;

        assign wr_ctrl = req.we && (req.idx == tmr_idx(t, TF_CTRL));
        assign wr_cmp  = req.we && (req.idx == tmr_idx(t, TF_CMP));
        assign wr_cnt  = req.we && (req.idx == tmr_idx(t, TF_CNT));

        sysctl_timer #(
            .W (DATA_W)
        ) i_timer (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (wr_ctrl),
            .wr_cmp  (wr_cmp),
            .wr_cnt  (wr_cnt),
            .wdata   (req.wdata),
            .ctrl_q  (tmr_ctrl[t]),
            .cmp_q   (tmr_cmp[t]),
            .cnt_q   (tmr_cnt[t]),
            .hit_q   (irq_timer[t])
        );

        assign tmr_en_v[t]   = tmr_ctrl[t].enable;
        assign tmr_auto_v[t] = tmr_ctrl[t].autorst;
    end

    // Plain writable words and the request strobes.
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out_q  <= '0;
            pin_ien_q  <= '0;
            shutdown_q <= 1'b0;
            reset_q    <= 1'b0;
        end else begin
            if (req.we && req.idx == IDX_PIN_OUT) begin
                pin_out_q <= req.wdata[GPIO_W-1:0];
            end
            if (req.we && req.idx == IDX_PIN_IEN) begin
                pin_ien_q <= req.wdata[GPIO_W-1:0];
            end
            shutdown_q <= req.we && (req.idx == IDX_CFG_CMD)
                          && (req.wdata[15:0] == CMD_SHUTDOWN);
            reset_q    <= req.we && (req.idx == IDX_SYSID);
        end
    end

    assign gpio_out     = pin_out_q;
    assign shutdown_req = shutdown_q;
    assign reset_req    = reset_q;

    // Read path: fixed words and timer words are decoded separately and merged.
    always_comb begin
        case (req.idx)
            IDX_PIN_IN:  misc_rdata = DATA_W'(pin_level);
            IDX_PIN_OUT: misc_rdata = DATA_W'(pin_out_q);
            IDX_PIN_IEN: misc_rdata = DATA_W'(pin_ien_q);
            IDX_CFG_CMD: misc_rdata = CFG_READY;
            IDX_CAPS:    misc_rdata = CAPS;
            IDX_SYSID:   misc_rdata = SYSID;
            default:     misc_rdata = '0;
        endcase
    end

    always_comb begin
        tmr_rdata = '0;
        for (int t = 0; t < N_TMR; t++) begin
            if (req.idx == tmr_idx(t, TF_CTRL)) tmr_rdata = DATA_W'(tmr_ctrl[t]);
            if (req.idx == tmr_idx(t, TF_CMP))  tmr_rdata = tmr_cmp[t];
            if (req.idx == tmr_idx(t, TF_CNT))  tmr_rdata = tmr_cnt[t];
        end
    end

    assign bus_rdata = misc_rdata | tmr_rdata;

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker
    import sysctl_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [IDX_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              shutdown_req,
    input logic              reset_req,
    input logic              irq_gpio,
    input logic [N_TMR-1:0]  irq_timer,
    input logic [GPIO_W-1:0] pin_ien_q,
    input logic [N_TMR-1:0]  tmr_en_v,
    input logic [N_TMR-1:0]  tmr_auto_v
);

    // R6: a shutdown strobe follows a matching command write
    a_r6_shutdown_cause: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(bus_we && bus_addr == IDX_CFG_CMD
                               && bus_wdata[15:0] == CMD_SHUTDOWN));

    // R7: a reset strobe follows a write to the ID word
    a_r7_reset_cause: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(bus_we && bus_addr == IDX_SYSID));

    // R9: a pin interrupt needs at least one enable bit set in the cycle before it
    a_r9_gpio_enabled: assert property (@(posedge clk) disable iff (rst)
        irq_gpio |-> $past(|pin_ien_q));

    // R6: the config word always reads the ready bit
    a_r6_cfg_ready: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == IDX_CFG_CMD) |-> (bus_rdata == CFG_READY));

    // R10: reserved words read zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'd3 || bus_addr == 4'd7 || bus_addr == 4'd11 || bus_addr == 4'd12)
        |-> (bus_rdata == '0));

    for (genvar t = 0; t < N_TMR; t++) begin : g_chk
        // R3: a one-shot hit leaves the timer disabled
        a_r3_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
            (irq_timer[t] && !tmr_auto_v[t]
             && !$past(bus_we && bus_addr == tmr_idx(t, TF_CTRL)))
            |-> !tmr_en_v[t]);

        // R4: an auto-restart hit keeps the timer enabled
        a_r4_auto_runs: assert property (@(posedge clk) disable iff (rst)
            (irq_timer[t] && tmr_auto_v[t]
             && !$past(bus_we && bus_addr == tmr_idx(t, TF_CTRL)))
            |-> tmr_en_v[t]);
    end

endmodule

bind soc_sysctl sysctl_checker #(.GPIO_W(GPIO_W)) i_sysctl_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .irq_gpio     (irq_gpio),
    .irq_timer    (irq_timer),
    .pin_ien_q    (pin_ien_q),
    .tmr_en_v     (tmr_en_v),
    .tmr_auto_v   (tmr_auto_v)
);

// File: tb/test_soc_sysctl.sv
`timescale 1ns/1ps
module test_soc_sysctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  gpio_in = 8'h01;
    logic [7:0]  gpio_out;
    logic        irq_gpio;
    logic [1:0]  irq_timer;
    logic        shutdown_req;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    soc_sysctl i_soc_sysctl (
        .clk          (clk),
        .rst          (rst),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .gpio_in      (gpio_in),
        .gpio_out     (gpio_out),
        .irq_gpio     (irq_gpio),
        .irq_timer    (irq_timer),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req)
    );

    // Register table: {index, write data, expected readback}
    localparam logic [67:0] VECS [0:10] = '{
        {4'd1,  32'hFFFF_FFA5, 32'h0000_00A5},   // R2 pin out
        {4'd2,  32'h0000_0003, 32'h0000_0003},   // R2 interrupt enable
        {4'd5,  32'h1234_5678, 32'h1234_5678},   // R3 timer0 compare
        {4'd9,  32'hCAFE_F00D, 32'hCAFE_F00D},   // R3 timer1 compare
        {4'd14, 32'hFFFF_FFFF, 32'h0000_0000},   // R8 capabilities read-only
        {4'd0,  32'h0000_0000, 32'h0000_0001},   // R8 pin input read-only
        {4'd3,  32'h0000_FFFF, 32'h0000_0000},   // R10 reserved
        {4'd12, 32'h0000_1234, 32'h0000_0000},   // R10 reserved
        {4'd13, 32'h0000_1234, 32'h0000_0001},   // R6 config keeps ready
        {4'd6,  32'h0000_0100, 32'h0000_0100},   // R11 held counter
        {4'd6,  32'hFFFF_FFFF, 32'h1234_5678}    // R5 clipped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives at a negedge, returns at the negedge after the write edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Counts edges until the timer interrupt is seen.
    task automatic wait_tmr(input int t, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq_timer[t] && k < 200);
    endtask

    function automatic logic [31:0] reset_value(input int i);
        case (i)
            0:       return 32'h1;
            13:      return 32'h1;
            14:      return 32'h0;
            15:      return 32'h1001_4D31;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        int k;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset defaults over the whole map
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            check($sformatf("R1 reset index %0d", i), v, reset_value(i));
        end
        check("R1 outputs low", {20'b0, gpio_out, irq_gpio, irq_timer, shutdown_req, reset_req}, 32'h0);

        // Table walk: write then read back (R2 R5 R8 R10 R6 R11)
        for (int i = 0; i < 11; i++) begin
            wr(VECS[i][67:64], VECS[i][63:32]);
            rd(VECS[i][67:64], v);
            check($sformatf("table row %0d", i), v, VECS[i][31:0]);
        end
        check("R2 pin_out follows", 32'(gpio_out), 32'hA5);
        check("R6 no shutdown on other value", 32'(shutdown_req), 32'h0);

        // R3 one-shot: start 2, compare 5
        wr(4'd5, 32'd5);
        wr(4'd6, 32'd2);
        wr(4'd4, 32'h1);
        wait_tmr(0, k);
        check("R3 one-shot latency", 32'(k), 32'd4);
        @(negedge clk);
        check("R3 pulse one cycle", 32'(irq_timer[0]), 32'h0);
        rd(4'd4, v);
        check("R3 enable self-cleared", v, 32'h0);
        rd(4'd6, v);
        check("R3 counter held at compare", v, 32'd5);
        repeat (8) @(negedge clk);
        check("R3 no second pulse", 32'(irq_timer[0]), 32'h0);

        // R4 auto-restart: timer1 compare 3 from 0
        wr(4'd9, 32'd3);
        wr(4'd10, 32'd0);
        wr(4'd8, 32'h3);
        wait_tmr(1, k);
        check("R4 first interval", 32'(k), 32'd4);
        rd(4'd10, v);
        check("R4 counter wrapped to zero", v, 32'd0);
        wait_tmr(1, k);
        check("R4 period compare+1", 32'(k), 32'd4);
        rd(4'd8, v);
        check("R4 enable kept", v, 32'h3);
        wr(4'd8, 32'h0);

        // R11 live counting and hold when disabled
        wr(4'd5, 32'd1000);
        wr(4'd6, 32'd0);
        wr(4'd4, 32'h1);
        rd(4'd6, v);
        check("R11 counter after enable", v, 32'd0);
        @(negedge clk);
        rd(4'd6, v);
        check("R11 counter advanced", v, 32'd1);
        wr(4'd4, 32'h0);
        rd(4'd6, v);
        @(negedge clk);
        @(negedge clk);
        rd(4'd6, v2);
        check("R11 disabled counter holds", v2, v);

        // R6 shutdown command
        wr(4'd13, 32'hABCD_000E);
        check("R6 shutdown pulse", 32'(shutdown_req), 32'h1);
        @(negedge clk);
        check("R6 shutdown one cycle", 32'(shutdown_req), 32'h0);
        wr(4'd13, 32'h0000_000F);
        check("R6 other command ignored", 32'(shutdown_req), 32'h0);

        // R7 reset request
        wr(4'd15, 32'h0);
        check("R7 reset pulse", 32'(reset_req), 32'h1);
        @(negedge clk);
        check("R7 reset one cycle", 32'(reset_req), 32'h0);
        rd(4'd15, v);
        check("R7 ID unchanged", v, 32'h1001_4D31);

        // R9 enabled bit 0 falls
        gpio_in = 8'h00;
        @(negedge clk);
        check("R9 no early irq", 32'(irq_gpio), 32'h0);
        @(negedge clk);
        rd(4'd0, v);
        check("R9 input after two edges", v, 32'h0);
        check("R9 irq not yet", 32'(irq_gpio), 32'h0);
        @(negedge clk);
        check("R9 irq on third edge", 32'(irq_gpio), 32'h1);
        @(negedge clk);
        check("R9 irq one cycle", 32'(irq_gpio), 32'h0);

        // R9 disabled bit 7 rises
        gpio_in = 8'h80;
        k = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq_gpio) k++;
        end
        check("R9 masked bit no irq", 32'(k), 32'h0);
        rd(4'd0, v);
        check("R9 masked bit still sampled", v, 32'h80);

        // R10 reserved write leaves neighbours unchanged
        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd7, v);
        check("R10 reserved 7 reads zero", v, 32'h0);
        rd(4'd8, v);
        check("R10 neighbour control intact", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule